// File: doc/BRIEF.md
# Guest Event Exit Classifier

This block sits beside the event delivery path of a virtualized core. For each incoming event it decides whether the event leaves the guest at once (a direct exit) or is handed to the guest. If the guest delivery of an exception or interrupt raises a second exit condition, the event exits indirectly instead. The event delivery itself is outside the block.

The classification is registered. It appears, with a result-valid flag, on the cycle after the event strobe. A direct exit caused by a debug exception or a page fault also produces two things. The first is a set of suppress flags that hold back the architectural updates that normal delivery would make. The second is an exit qualification word that carries the information those updates would have recorded. A direct NMI exit also arms a blocking flag, and that flag becomes set only when the surrounding logic reports that the exit has finished.

Top module: `exit_classifier`

## Requirements
- R1: An exception (kind code 0) exits directly when its vector is below 32 and the exception bitmap bit at that vector index is 1. An exception with a vector of 32 or more never exits directly.
- R2: An NMI (kind 1) exits directly exactly when nmi_exit_en is 1. An external interrupt (kind 2) exits directly exactly when ext_exit_en is 1.
- R3: A software interrupt (kind 3) never exits directly.
- R4: A startup IPI (kind 4) exits directly exactly when wait_startup is 1.
- R5: An INIT (kind 5) exits directly exactly when wait_startup is 0. Kind codes 6 and 7 never exit.
- R6: Kinds 0 to 3 exit indirectly when they do not exit directly and deliver_fault is 1. Kinds 4 to 7 never exit indirectly.
- R7: exit_direct and exit_indirect are never 1 together, and exit_any equals their OR.
- R8: A direct exit of exception vector 1 sets suppress bits 0 (debug status), 1 (general-detect) and 2 (last-branch enable), and drives dbg_info onto exit_qual.
- R9: A direct exit of exception vector 14 sets suppress bit 3 (fault address) and drives fault_addr onto exit_qual. In every other case suppress is 0 and exit_qual is 0.
- R10: The outputs for a strobe on evt_valid appear on the next cycle with res_valid 1. On a cycle after no strobe, res_valid, the exit flags and suppress are 0.
- R11: A direct NMI exit sets nmi_blocked only on the cycle after exit_done is seen high, at the earliest in the cycle that follows the classification. nmi_unblock clears nmi_blocked.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe |
| evt_kind | input | 3 | Event kind code |
| evt_vector | input | 8 | Exception vector |
| exc_bitmap | input | 32 | Per-vector exception exit bits |
| nmi_exit_en | input | 1 | NMI exit control |
| ext_exit_en | input | 1 | External-interrupt exit control |
| wait_startup | input | 1 | Core is waiting for a startup IPI |
| deliver_fault | input | 1 | Guest delivery raised a secondary exit condition |
| dbg_info | input | 64 | Debug-exception details |
| fault_addr | input | 64 | Faulting linear address |
| exit_done | input | 1 | Exit transition has completed |
| nmi_unblock | input | 1 | Clears NMI blocking |
| res_valid | output | 1 | Classification valid |
| exit_direct | output | 1 | Event exits directly |
| exit_indirect | output | 1 | Event exits through its delivery |
| exit_any | output | 1 | Either kind of exit |
| suppress | output | 4 | Architectural-update suppress flags |
| exit_qual | output | 64 | Exit qualification |
| nmi_blocked | output | 1 | NMI blocking is in force |

## Verification
Exceptions are applied with bitmap bits both set and clear, at vectors 0, 1, 14 and 31 and at vectors past the bitmap. This separates the indexed lookup from an off-by-one or truncated index. Each control-gated kind is applied with its control both on and off. Startup IPI and INIT are applied in both activity states, which shows that the two react in opposite ways. Adding deliver_fault to each kind separates the indirect path from the direct one and from the kinds that can never exit indirectly. An NMI sequence with exit_done delayed shows that blocking waits for completion.

// File: rtl/exit_cls_pkg.sv
package exit_cls_pkg;
  typedef enum logic [2:0] {
    EV_EXC   = 3'd0,
    EV_NMI   = 3'd1,
    EV_EXT   = 3'd2,
    EV_SWI   = 3'd3,
    EV_SIPI  = 3'd4,
    EV_INIT  = 3'd5,
    EV_RSV6  = 3'd6,
    EV_RSV7  = 3'd7
  } ev_kind_e;

  localparam int SUP_W      = 4;
  localparam int SUP_DBGST  = 0;
  localparam int SUP_GD     = 1;
  localparam int SUP_LBR    = 2;
  localparam int SUP_FADDR  = 3;
endpackage

// File: rtl/exit_decider.sv
module exit_decider
  import exit_cls_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int BITMAP_W = 32
) (
  input  logic [2:0]          kind,
  input  logic [VEC_W-1:0]    vector,
  input  logic [BITMAP_W-1:0] bitmap,
  input  logic                nmi_exit_en,
  input  logic                ext_exit_en,
  input  logic                wait_startup,
  input  logic                deliver_fault,
  output logic                direct,
  output logic                indirect
);
  localparam int IDX_W = $clog2(BITMAP_W);

  logic in_range;
  logic bm_hit;
  logic redeliverable;

  assign in_range = (vector < VEC_W'(BITMAP_W));
  assign bm_hit   = in_range && bitmap[vector[IDX_W-1:0]];

  always_comb begin
    direct        = 1'b0;
    redeliverable = 1'b0;
    case (ev_kind_e'(kind))
      EV_EXC:  begin direct = bm_hit;      redeliverable = 1'b1; end
      EV_NMI:  begin direct = nmi_exit_en; redeliverable = 1'b1; end
      EV_EXT:  begin direct = ext_exit_en; redeliverable = 1'b1; end
      EV_SWI:  begin direct = 1'b0;        redeliverable = 1'b1; end
      EV_SIPI: direct = wait_startup;
      EV_INIT: direct = !wait_startup;
      default: direct = 1'b0;
    endcase
  end

  assign indirect = redeliverable && !direct && deliver_fault;
endmodule

// File: rtl/exit_side_effects.sv
module exit_side_effects
  import exit_cls_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int QUAL_W  = 64,
  parameter int DB_VEC  = 1,
  parameter int PF_VEC  = 14
) (
  input  logic [2:0]       kind,
  input  logic [VEC_W-1:0] vector,
  input  logic             direct,
  input  logic [QUAL_W-1:0] dbg_info,
  input  logic [QUAL_W-1:0] fault_addr,
  output logic [SUP_W-1:0]  suppress,
  output logic [QUAL_W-1:0] qual
);
  logic is_exc_direct;
  assign is_exc_direct = direct && (ev_kind_e'(kind) == EV_EXC);

  always_comb begin
    suppress = '0;
    qual     = '0;
    if (is_exc_direct && vector == VEC_W'(DB_VEC)) begin
      suppress[SUP_DBGST] = 1'b1;
      suppress[SUP_GD]    = 1'b1;
      suppress[SUP_LBR]   = 1'b1;
      qual                = dbg_info;
    end else if (is_exc_direct && vector == VEC_W'(PF_VEC)) begin
      suppress[SUP_FADDR] = 1'b1;
      qual                = fault_addr;
    end
  end
endmodule

// File: rtl/nmi_block_tracker.sv
module nmi_block_tracker (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic exit_done,
  input  logic unblock,
  output logic blocked
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      blocked <= 1'b0;
    end else begin
      if (pending && exit_done) begin
        pending <= 1'b0;
        blocked <= 1'b1;
      end else begin
        if (arm) pending <= 1'b1;
        if (unblock) blocked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exit_classifier.sv
module exit_classifier
  import exit_cls_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int BITMAP_W = 32,
  parameter int QUAL_W   = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt_valid,
  input  logic [2:0]          evt_kind,
  input  logic [VEC_W-1:0]    evt_vector,
  input  logic [BITMAP_W-1:0] exc_bitmap,
  input  logic                nmi_exit_en,
  input  logic                ext_exit_en,
  input  logic                wait_startup,
  input  logic                deliver_fault,
  input  logic [QUAL_W-1:0]   dbg_info,
  input  logic [QUAL_W-1:0]   fault_addr,
  input  logic                exit_done,
  input  logic                nmi_unblock,
  output logic                res_valid,
  output logic                exit_direct,
  output logic                exit_indirect,
  output logic                exit_any,
  output logic [3:0]          suppress,
  output logic [QUAL_W-1:0]   exit_qual,
  output logic                nmi_blocked
);
  logic              c_direct, c_indirect;
  logic [SUP_W-1:0]  c_sup;
  logic [QUAL_W-1:0] c_qual;
  logic              nmi_arm;

  exit_decider #(.VEC_W(VEC_W), .BITMAP_W(BITMAP_W)) u_dec (
    .kind(evt_kind), .vector(evt_vector), .bitmap(exc_bitmap),
    .nmi_exit_en(nmi_exit_en), .ext_exit_en(ext_exit_en),
    .wait_startup(wait_startup), .deliver_fault(deliver_fault),
    .direct(c_direct), .indirect(c_indirect)
  );

  exit_side_effects #(.VEC_W(VEC_W), .QUAL_W(QUAL_W)) u_fx (
    .kind(evt_kind), .vector(evt_vector), .direct(c_direct),
    .dbg_info(dbg_info), .fault_addr(fault_addr),
    .suppress(c_sup), .qual(c_qual)
  );

  assign nmi_arm = evt_valid && c_direct && (ev_kind_e'(evt_kind) == EV_NMI);

  nmi_block_tracker u_nmi (
    .clk(clk), .rst(rst), .arm(nmi_arm), .exit_done(exit_done),
    .unblock(nmi_unblock), .blocked(nmi_blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      exit_direct   <= 1'b0;
      exit_indirect <= 1'b0;
      exit_any      <= 1'b0;
      suppress      <= '0;
      exit_qual     <= '0;
    end else begin
      res_valid     <= evt_valid;
      exit_direct   <= evt_valid && c_direct;
      exit_indirect <= evt_valid && c_indirect;
      exit_any      <= evt_valid && (c_direct || c_indirect);
      suppress      <= evt_valid ? c_sup  : '0;
      exit_qual     <= evt_valid ? c_qual : '0;
    end
  end
endmodule

// File: rtl/exit_classifier_chk.sv
module exit_classifier_chk (
  input logic       clk,
  input logic       rst,
  input logic       evt_valid,
  input logic [2:0] evt_kind,
  input logic       wait_startup,
  input logic       exit_done,
  input logic       res_valid,
  input logic       exit_direct,
  input logic       exit_indirect,
  input logic       exit_any,
  input logic [3:0] suppress,
  input logic       nmi_blocked
);
  // R7
  no_dual_exit_chk: assert property (@(posedge clk) disable iff (rst)
    !(exit_direct && exit_indirect));
  // R7
  any_matches_chk: assert property (@(posedge clk) disable iff (rst)
    exit_any == (exit_direct || exit_indirect));
  // R10
  strobe_result_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> res_valid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> (!res_valid && !exit_any && suppress == 4'd0));
  // R8
  sup_needs_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (suppress != 4'd0) |-> exit_direct);
  // R4
  sipi_awake_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == 3'd4 && !wait_startup) |=> !exit_direct);
  // R11
  block_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_blocked) |-> $past(exit_done));
endmodule

bind exit_classifier exit_classifier_chk u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
  .wait_startup(wait_startup), .exit_done(exit_done), .res_valid(res_valid),
  .exit_direct(exit_direct), .exit_indirect(exit_indirect),
  .exit_any(exit_any), .suppress(suppress), .nmi_blocked(nmi_blocked)
);

// File: tb/tb_exit_classifier.sv
module tb_exit_classifier;
  logic        clk = 1'b0;
  logic        rst;
  logic        evt_valid;
  logic [2:0]  evt_kind;
  logic [7:0]  evt_vector;
  logic [31:0] exc_bitmap;
  logic        nmi_exit_en, ext_exit_en, wait_startup, deliver_fault;
  logic [63:0] dbg_info, fault_addr;
  logic        exit_done, nmi_unblock;
  logic        res_valid, exit_direct, exit_indirect, exit_any, nmi_blocked;
  logic [3:0]  suppress;
  logic [63:0] exit_qual;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    string       tag;
    logic        dir;
    logic        ind;
    logic [3:0]  sup;
    logic [63:0] qual;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  exit_classifier dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected values computed from the requirements.
  function automatic exp_t model(string tag, logic [2:0] k, logic [7:0] v);
    exp_t e;
    e.tag = tag; e.dir = 0; e.ind = 0; e.sup = 0; e.qual = 0;
    case (k)
      3'd0: e.dir = (v < 32) && exc_bitmap[v[4:0]];
      3'd1: e.dir = nmi_exit_en;
      3'd2: e.dir = ext_exit_en;
      3'd4: e.dir = wait_startup;
      3'd5: e.dir = !wait_startup;
      default: e.dir = 0;
    endcase
    e.ind = (k <= 3'd3) && !e.dir && deliver_fault;
    if (k == 3'd0 && e.dir && v == 8'd1) begin e.sup = 4'b0111; e.qual = dbg_info; end
    if (k == 3'd0 && e.dir && v == 8'd14) begin e.sup = 4'b1000; e.qual = fault_addr; end
    return e;
  endfunction

  task automatic send(string tag, logic [2:0] k, logic [7:0] v);
    @(negedge clk);
    evt_valid = 1; evt_kind = k; evt_vector = v;
    sb.push_back(model(tag, k, v));
    @(negedge clk);
    evt_valid = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) chk("R10 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " direct"}, exit_direct, e.dir);
        chk({e.tag, " indirect"}, exit_indirect, e.ind);
        chk({e.tag, " R7 any"}, exit_any, e.dir | e.ind);
        chk({e.tag, " suppress"}, suppress, e.sup);
        chk({e.tag, " qual"}, exit_qual, e.qual);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; evt_valid = 0; evt_kind = 0; evt_vector = 0; exc_bitmap = 0;
    nmi_exit_en = 0; ext_exit_en = 0; wait_startup = 0; deliver_fault = 0;
    dbg_info = 64'h0000_00AB_CDEF_0123; fault_addr = 64'hFFFF_8000_1234_5000;
    exit_done = 0; nmi_unblock = 0;
    repeat (3) @(negedge clk);
    // R12
    chk("R12 reset res_valid", res_valid, 0);
    chk("R12 reset exit_any", exit_any, 0);
    chk("R12 reset qual", exit_qual, 0);
    chk("R12 reset blocked", nmi_blocked, 0);
    rst = 0;

    exc_bitmap = 32'h8000_4003;
    send("R1 vec0 set", 3'd0, 8'd0);
    send("R8 debug direct", 3'd0, 8'd1);
    send("R9 page fault direct", 3'd0, 8'd14);
    send("R1 vec31 set", 3'd0, 8'd31);
    send("R1 vec2 clear", 3'd0, 8'd2);
    send("R1 vec32 out of range", 3'd0, 8'd32);
    send("R1 vec64 alias", 3'd0, 8'd64);
    exc_bitmap = 32'h0;
    send("R9 page fault not exiting", 3'd0, 8'd14);
    deliver_fault = 1;
    send("R6 exception indirect", 3'd0, 8'd14);
    send("R6 swi indirect", 3'd3, 8'd0);
    send("R6 nmi indirect", 3'd1, 8'd0);
    send("R6 sipi never indirect", 3'd4, 8'd0);
    nmi_exit_en = 1;
    send("R6 nmi direct wins", 3'd1, 8'd0);
    deliver_fault = 0;
    send("R3 swi", 3'd3, 8'd0);
    send("R2 ext off", 3'd2, 8'd0);
    ext_exit_en = 1;
    send("R2 ext on", 3'd2, 8'd0);
    nmi_exit_en = 0;
    send("R2 nmi off", 3'd1, 8'd0);
    send("R4 sipi awake", 3'd4, 8'd0);
    send("R5 init awake", 3'd5, 8'd0);
    send("R5 reserved kind", 3'd6, 8'd0);
    wait_startup = 1;
    send("R4 sipi waiting", 3'd4, 8'd0);
    send("R5 init waiting", 3'd5, 8'd0);
    wait_startup = 0;

    // R10 idle cycle
    @(negedge clk);
    chk("R10 idle res_valid", res_valid, 0);
    chk("R10 idle direct", exit_direct, 0);

    // R11 NMI blocking sequence
    nmi_exit_en = 1;
    send("R11 nmi direct", 3'd1, 8'd0);
    repeat (3) @(negedge clk);
    chk("R11 blocked before done", nmi_blocked, 0);
    exit_done = 1;
    @(negedge clk);
    exit_done = 0;
    chk("R11 blocked after done", nmi_blocked, 1);
    @(negedge clk);
    chk("R11 blocked held", nmi_blocked, 1);
    nmi_unblock = 1;
    @(negedge clk);
    nmi_unblock = 0;
    chk("R11 unblocked", nmi_blocked, 0);
    exit_done = 1;
    @(negedge clk);
    exit_done = 0;
    chk("R11 done without nmi", nmi_blocked, 0);

    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule